// File: doc/BRIEF.md
# Link Clock Ratio Controller

This block derives a slow link clock from the core clock by dividing it by a programmable ratio. Software sets the ratio, and an output-divider select meant for the clock source, through one control word. The new values are written into the word first. They take effect only when a write sets the commit bit, and that commit is accepted only while the link port is off.

An accepted commit switches the division at once. The link-clock period that is running at that moment is cut short and a period at the new ratio starts. A fixed settling window of core cycles then follows. During the window the busy flag is high and the link-port enable is held off, whatever the enable request says. A commit that arrives while the link port is enabled is dropped and sets a sticky error bit. Software clears that bit by writing 1 to it.

Top module: `lclk_ratio_ctrl`

## Requirements
- R1: After reset, lclk, busy, lp_en and pll_odiv are 0, reg_rdata reads 0 and the active ratio is divide-by-2. lclk stays low for the first full period (2 core cycles) and then starts toggling.
- R2: The ratio field is reg_wdata[22:21]. Codes 0, 1, 2 and 3 select a link-clock period of 2, 3, 4 and 5 core cycles. lclk is high for the first floor(N/2) cycles of each period.
- R3: A write with bit 9 clear stores the fields for readback (ratio at reg_rdata[22:21], output divider at reg_rdata[7:6]). It changes neither the lclk period nor pll_odiv.
- R4: A write with bit 9 set while lp_en is low commits the written fields on that clock edge. busy is then high for exactly 15 core cycles, starting in the next cycle.
- R5: A commit ends the link-clock period in progress. In the cycle after the commit, lclk is high and begins a period at the new ratio.
- R6: lp_en equals lp_en_req while busy is low, and it is 0 whenever busy is high.
- R7: A write with bit 9 set while lp_en is high changes neither the ratio nor pll_odiv and does not raise busy. It sets the error bit reg_rdata[12], which stays set until a write with bit 12 set clears it.
- R8: Bit 9 always reads back as 0.
- R9: The output-divider field reg_wdata[7:6] drives pll_odiv after a commit. A commit that changes only this field gets the same 15-cycle window and nothing longer.
- R10: A commit while busy is high restarts the window, so busy then lasts 15 cycles from the latest commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word readback |
| lp_en_req | input | 1 | Link-port enable request |
| lp_en | output | 1 | Granted link-port enable |
| lclk | output | 1 | Divided link clock |
| busy | output | 1 | Settling window in progress |
| pll_odiv | output | 2 | Active output-divider select |

## Verification
The bench uses the default parameters: a 15-cycle settling window, a base divisor of 2 and a high phase of floor(N/2). With these values all four ratio codes produce periods of 2 to 5 core cycles, which the bench can measure edge to edge. The window is short enough to count cycle by cycle, and a second commit can land partway through it. The low base divisor allows a truncation test in which a divide-by-5 period is cut at its third cycle and replaced by a divide-by-2 period.

// File: rtl/lclk_pkg.sv
package lclk_pkg;
   localparam int SEL_W = 2;

   typedef struct packed {
      logic [SEL_W-1:0] ratio;
      logic [SEL_W-1:0] odiv;
   } lclk_sel_t;
endpackage

// File: rtl/lclk_cfg_regs.sv
module lclk_cfg_regs
   import lclk_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ODIV_LSB   = 6,
   parameter int RATIO_LSB  = 21,
   parameter int COMMIT_BIT = 9,
   parameter int ERR_BIT    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              lp_en,
   output lclk_sel_t         act_sel,
   output logic              commit,
   output logic [DATA_W-1:0] rdata
);
   lclk_sel_t wr_sel;
   lclk_sel_t pend_sel;
   logic      err_q;
   logic      wr_commit;
   logic      reject;

   assign wr_sel.ratio = wdata[RATIO_LSB +: SEL_W];
   assign wr_sel.odiv  = wdata[ODIV_LSB +: SEL_W];
   assign wr_commit    = wr & wdata[COMMIT_BIT];
   assign commit       = wr_commit & ~lp_en;
   assign reject       = wr_commit & lp_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_sel <= '0;
         act_sel  <= '0;
         err_q    <= 1'b0;
      end else begin
         if (wr)
            pend_sel <= wr_sel;
         if (commit)
            act_sel <= wr_sel;
         if (reject)
            err_q <= 1'b1;
         else if (wr && wdata[ERR_BIT])
            err_q <= 1'b0;
      end
   end

   always_comb begin
      rdata                         = '0;
      rdata[RATIO_LSB +: SEL_W]     = pend_sel.ratio;
      rdata[ODIV_LSB +: SEL_W]      = pend_sel.odiv;
      rdata[ERR_BIT]                = err_q;
   end
endmodule

// File: rtl/lclk_settle_timer.sv
module lclk_settle_timer #(
   parameter int SETTLE_CYC = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);

   generate
      if (SETTLE_CYC == 0) begin : g_no_window
         assign busy = 1'b0;
      end else begin : g_window
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (start)
               cnt <= CNT_W'(SETTLE_CYC);
            else if (cnt != '0)
               cnt <= cnt - 1'b1;
         end
         assign busy = (cnt != '0);
      end
   endgenerate
endmodule

// File: rtl/lclk_div_gen.sv
module lclk_div_gen
   import lclk_pkg::*;
#(
   parameter int DIV_BASE = 2,
   parameter bit HI_LONG  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             apply,
   input  logic [SEL_W-1:0] sel,
   output logic             lclk
);
   localparam int DIV_MAX = DIV_BASE + (1 << SEL_W) - 1;
   localparam int DIV_W   = $clog2(DIV_MAX + 1);

   logic [DIV_W-1:0] div_n;
   logic [DIV_W-1:0] hi_len;
   logic [DIV_W-1:0] ph;
   logic [DIV_W-1:0] ph_inc;
   logic             run;
   logic             lclk_q;

   assign div_n  = DIV_W'(DIV_BASE) + DIV_W'(sel);
   assign ph_inc = ph + 1'b1;

   generate
      if (HI_LONG) begin : g_hi_ceil
         assign hi_len = DIV_W'((div_n + 1'b1) >> 1);
      end else begin : g_hi_floor
         assign hi_len = div_n >> 1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= '0;
         run    <= 1'b0;
         lclk_q <= 1'b0;
      end else if (apply) begin
         ph     <= '0;
         lclk_q <= run;
      end else if (ph_inc >= div_n) begin
         ph     <= '0;
         run    <= 1'b1;
         lclk_q <= 1'b1;
      end else begin
         ph     <= ph_inc;
         lclk_q <= run && (ph_inc < hi_len);
      end
   end

   assign lclk = lclk_q;
endmodule

// File: rtl/lclk_ratio_ctrl.sv
module lclk_ratio_ctrl
   import lclk_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ODIV_LSB   = 6,
   parameter int RATIO_LSB  = 21,
   parameter int COMMIT_BIT = 9,
   parameter int ERR_BIT    = 12,
   parameter int SETTLE_CYC = 15,
   parameter int DIV_BASE   = 2,
   parameter bit HI_LONG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              lp_en_req,
   output logic              lp_en,
   output logic              lclk,
   output logic              busy,
   output logic [SEL_W-1:0]  pll_odiv
);
   generate
      if (DIV_BASE < 2) begin : g_bad_base
         $error("DIV_BASE must be at least 2");
      end
      if (RATIO_LSB + SEL_W > DATA_W || ODIV_LSB + SEL_W > DATA_W) begin : g_bad_field
         $error("select fields exceed the control word");
      end
      if (COMMIT_BIT >= DATA_W || ERR_BIT >= DATA_W || COMMIT_BIT == ERR_BIT) begin : g_bad_bit
         $error("commit and error bits must be distinct and inside the word");
      end
   endgenerate

   lclk_sel_t act_sel;
   logic      commit;

   lclk_cfg_regs #(
      .DATA_W(DATA_W), .ODIV_LSB(ODIV_LSB), .RATIO_LSB(RATIO_LSB),
      .COMMIT_BIT(COMMIT_BIT), .ERR_BIT(ERR_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata), .lp_en(lp_en),
      .act_sel(act_sel), .commit(commit), .rdata(reg_rdata)
   );

   lclk_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy)
   );

   lclk_div_gen #(.DIV_BASE(DIV_BASE), .HI_LONG(HI_LONG)) u_div (
      .clk(clk), .rst_n(rst_n), .apply(commit), .sel(act_sel.ratio), .lclk(lclk)
   );

   assign lp_en    = lp_en_req & ~busy;
   assign pll_odiv = act_sel.odiv;
endmodule

// File: rtl/lclk_ratio_ctrl_chk.sv
module lclk_ratio_ctrl_chk #(
   parameter int DATA_W     = 32,
   parameter int COMMIT_BIT = 9,
   parameter int ERR_BIT    = 12,
   parameter int SETTLE_CYC = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              lp_en,
   input logic              busy,
   input logic [1:0]        pll_odiv
);
   localparam int RUN_W = $clog2(SETTLE_CYC + 2);

   logic             c_commit;
   logic [RUN_W-1:0] run_cnt;

   assign c_commit = reg_wr && reg_wdata[COMMIT_BIT] && !lp_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_cnt <= '0;
      else if (c_commit)
         run_cnt <= '0;
      else if (busy)
         run_cnt <= run_cnt + 1'b1;
      else
         run_cnt <= '0;
   end

   // R6
   p_enable_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !lp_en);

   // R4, R10
   p_busy_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
      c_commit |=> busy);

   p_busy_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_cnt < RUN_W'(SETTLE_CYC)));

   p_busy_length_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_cnt == RUN_W'(SETTLE_CYC)));

   // R7
   p_reject_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[COMMIT_BIT] && lp_en) |=> (reg_rdata[ERR_BIT] && !busy));

   // R3
   p_odiv_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !c_commit |=> $stable(pll_odiv));

   // R8
   p_commit_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[COMMIT_BIT]);
endmodule

bind lclk_ratio_ctrl lclk_ratio_ctrl_chk #(
   .DATA_W(DATA_W), .COMMIT_BIT(COMMIT_BIT), .ERR_BIT(ERR_BIT), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .lp_en(lp_en), .busy(busy), .pll_odiv(pll_odiv)
);

// File: tb/test_lclk_ratio_ctrl.sv
module test_lclk_ratio_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        lp_en_req = 1'b0;
   logic        lp_en;
   logic        lclk;
   logic        busy;
   logic [1:0]  pll_odiv;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // ratio code, expected period, expected high cycles
   localparam int VEC[5][3] = '{'{0, 2, 1}, '{1, 3, 1}, '{2, 4, 2}, '{3, 5, 2}, '{1, 3, 1}};

   always #4 clk = ~clk;

   lclk_ratio_ctrl i_lclk_ratio_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .lp_en_req(lp_en_req), .lp_en(lp_en),
      .lclk(lclk), .busy(busy), .pll_odiv(pll_odiv)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int ratio, input int odiv, input bit cm, input bit eclr);
      logic [31:0] w;
      w = '0;
      w[22:21] = 2'(ratio);
      w[7:6]   = 2'(odiv);
      w[9]     = cm;
      w[12]    = eclr;
      return w;
   endfunction

   task automatic wr(input logic [31:0] d);
      reg_wr    = 1'b1;
      reg_wdata = d;
      @(negedge clk);
      reg_wr    = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic busy_len(output int n);
      n = 0;
      while (busy === 1'b1 && n < 100) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic meas(output int per, output int hi);
      int g;
      g = 0;
      per = 0;
      hi = 0;
      while (lclk !== 1'b0 && g < 50) begin g++; @(negedge clk); end
      while (lclk !== 1'b1 && g < 100) begin g++; @(negedge clk); end
      while (lclk === 1'b1 && g < 150) begin g++; hi++; per++; @(negedge clk); end
      while (lclk === 1'b0 && g < 200) begin g++; per++; @(negedge clk); end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int per;
      int hi;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state and first held-low period
      check(lclk == 1'b0, "R1 lclk", int'(lclk), 0);
      check(busy == 1'b0 && lp_en == 1'b0, "R1 busy/lp_en", int'(busy), 0);
      check(reg_rdata == 32'h0, "R1 rdata", int'(reg_rdata), 0);
      check(pll_odiv == 2'd0, "R1 pll_odiv", int'(pll_odiv), 0);
      @(negedge clk);
      check(lclk == 1'b0, "R1 held low", int'(lclk), 0);
      @(negedge clk);
      check(lclk == 1'b1, "R1 first rise", int'(lclk), 1);
      meas(per, hi);
      check(per == 2, "R1 default period", per, 2);

      // R2 ratio table
      for (int i = 0; i < 5; i++) begin
         wr(mk(VEC[i][0], 0, 1'b1, 1'b0));
         check(busy == 1'b1, "R4 busy after commit", int'(busy), 1);
         check(reg_rdata[9] == 1'b0, "R8 commit bit reads 0", int'(reg_rdata[9]), 0);
         check(reg_rdata[22:21] == 2'(VEC[i][0]), "R3 ratio readback", int'(reg_rdata[22:21]), VEC[i][0]);
         busy_len(n);
         check(n == 15, "R4 window length", n, 15);
         meas(per, hi);
         check(per == VEC[i][1], "R2 period", per, VEC[i][1]);
         check(hi == VEC[i][2], "R2 high time", hi, VEC[i][2]);
      end

      // R3 write without commit
      wr(mk(3, 1, 1'b0, 1'b0));
      check(reg_rdata[22:21] == 2'd3 && reg_rdata[7:6] == 2'd1, "R3 pending readback", int'(reg_rdata), 32'h0060_0040);
      check(busy == 1'b0, "R3 no window", int'(busy), 0);
      check(pll_odiv == 2'd0, "R3 pll_odiv unchanged", int'(pll_odiv), 0);
      meas(per, hi);
      check(per == 3, "R3 period unchanged", per, 3);

      // R9 output-divider-only commit
      wr(mk(1, 2, 1'b1, 1'b0));
      check(pll_odiv == 2'd2, "R9 pll_odiv", int'(pll_odiv), 2);
      busy_len(n);
      check(n == 15, "R9 window length", n, 15);

      // R10 restart during window
      wr(mk(1, 2, 1'b1, 1'b0));
      repeat (5) @(negedge clk);
      wr(mk(1, 2, 1'b1, 1'b0));
      busy_len(n);
      check(n == 15, "R10 restarted window", n, 15);

      // R6 enable interlock
      wr(mk(1, 2, 1'b1, 1'b0));
      lp_en_req = 1'b1;
      #1;
      check(lp_en == 1'b0, "R6 blocked while busy", int'(lp_en), 0);
      busy_len(n);
      check(lp_en == 1'b1, "R6 granted after window", int'(lp_en), 1);

      // R7 commit while enabled
      wr(mk(3, 3, 1'b1, 1'b0));
      check(busy == 1'b0, "R7 no window", int'(busy), 0);
      check(reg_rdata[12] == 1'b1, "R7 error set", int'(reg_rdata[12]), 1);
      check(pll_odiv == 2'd2, "R7 pll_odiv kept", int'(pll_odiv), 2);
      meas(per, hi);
      check(per == 3, "R7 period kept", per, 3);
      check(reg_rdata[12] == 1'b1, "R7 error sticky", int'(reg_rdata[12]), 1);
      wr(mk(3, 3, 1'b0, 1'b1));
      check(reg_rdata[12] == 1'b0, "R7 error cleared", int'(reg_rdata[12]), 0);
      lp_en_req = 1'b0;
      @(negedge clk);

      // R5 truncation of the running period
      wr(mk(3, 2, 1'b1, 1'b0));
      busy_len(n);
      n = 0;
      while (lclk !== 1'b0 && n < 20) begin n++; @(negedge clk); end
      while (lclk !== 1'b1 && n < 40) begin n++; @(negedge clk); end
      @(negedge clk);
      @(negedge clk);
      check(lclk == 1'b0, "R5 mid period low", int'(lclk), 0);
      wr(mk(0, 2, 1'b1, 1'b0));
      check(lclk == 1'b1, "R5 new period starts", int'(lclk), 1);
      @(negedge clk);
      check(lclk == 1'b0, "R5 divide-by-2 low", int'(lclk), 0);
      meas(per, hi);
      check(per == 2, "R5 new period", per, 2);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule